// File: doc/BRIEF.md
# Serial Transmitter with Holding Queue

This block turns bytes handed over by a host into asynchronous serial frames on a single output line. Bytes arrive on a valid/ready stream port. They wait in a holding store that is either one byte deep or a full queue, as the `fifo_en` control selects. A separate shift engine takes one byte at a time out of the store and sends it as a frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts 16 pulses of the `tick16` oversampling strobe, which is generated outside the block.

Two plain status outputs are provided. `hold_empty` says that no byte is waiting in the store. `tx_empty` says that the shift engine has also finished its last stop bit. No fill count is reported. A break control holds the line low while it is set.

The stream rules are as follows. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The host may hold `in_valid` and `in_data` while `in_ready` is low. Nothing is stored during those cycles. The frame settings (`data_len`, `parity_en`, `parity_mode`, `two_stop`) are captured when a byte enters the shift engine. The storage mode (`fifo_en`) should only be changed while `tx_empty` is high.

Top module: `ser_tx_queue`

## Requirements
- R1: After reset `txd` is 1, and `hold_empty`, `tx_empty` and `in_ready` are all 1.
- R2: `in_ready` is 1 exactly when fewer bytes are stored than the capacity. The capacity is 1 when `fifo_en`=0 and DEPTH (16) when `fifo_en`=1. A cycle with `in_valid`=1 and `in_ready`=0 stores nothing.
- R3: Every accepted byte is sent exactly once, in the order it was accepted.
- R4: A frame starts with one low bit, followed by N data bits sent LSB first. N is 5 + `data_len` (code 0 gives 5 bits, code 3 gives 8 bits). Each bit lasts 16 `tick16` pulses.
- R5: When `parity_en`=1, one parity bit follows the data bits. `parity_mode` selects its value: 0 makes the count of ones over the data and parity bits even, 1 makes it odd, 2 always sends 1, and 3 always sends 0.
- R6: The frame ends with one high stop bit when `two_stop`=0, or two when `two_stop`=1.
- R7: `hold_empty` is 1 exactly when no byte is waiting in the store. When the shift engine is idle, an accepted byte moves into it on the clock edge that follows its acceptance.
- R8: `tx_empty` is 1 only when the store is empty and the shift engine has finished its last stop bit. While the final frame is still on the line, `hold_empty`=1 and `tx_empty`=0.
- R9: While `break_en`=1, `txd` is 0. Break leaves `hold_empty` and `tx_empty` unchanged, and `txd` returns to 1 when break is released on an idle line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling strobe, 16 pulses per bit |
| fifo_en | input | 1 | 1 selects queue storage, 0 selects single-byte storage |
| data_len | input | 2 | Data bit count minus 5 |
| parity_en | input | 1 | Adds a parity bit to each frame |
| parity_mode | input | 2 | 0 even, 1 odd, 2 constant 1, 3 constant 0 |
| two_stop | input | 1 | 1 selects two stop bits |
| break_en | input | 1 | Forces `txd` low |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Store has room for a byte |
| in_data | input | 8 | Stream byte |
| hold_empty | output | 1 | No byte waiting in the store |
| tx_empty | output | 1 | Store empty and shift engine idle |
| txd | output | 1 | Serial output |

## Verification
The bench holds `in_valid` high against a full single-byte store and then checks that the frame count matches what was accepted. A design that let the held byte through, or overwrote the stored one, would send an extra frame or a wrong one. It fills the queue while a frame is in flight and checks that `in_ready` drops at exactly sixteen stored bytes. It also watches the window where the last byte has left the store but is still on the line; a design that raised `tx_empty` as soon as the store drained would fail there. Frames are decoded at each bit centre for every data length, for every parity mode and for both stop counts, so a wrong parity polarity, a miscounted length or a missing second stop bit shows up as a mismatch against the scoreboard.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {PAR_EVEN, PAR_ODD, PAR_ONE, PAR_ZERO} par_mode_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    par_mode_e  par;
    logic       two_stop;
  } frame_cfg_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} tx_state_e;
endpackage

// File: rtl/ser_tx_store.sv
module ser_tx_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rp];
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16,
  localparam int SW = $clog2(OVS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  frame_cfg_t   cfg,
  input  logic         brk,
  output logic         idle,
  output logic         txd
);
  tx_state_e    st;
  logic [SW-1:0] sub;
  logic [3:0]    bitn;
  logic [3:0]    nbits;
  logic [W-1:0]  shreg;
  logic          pbit, par_en_q, two_stop_q;

  function automatic logic calc_par(logic [W-1:0] d, logic [3:0] n, par_mode_e m);
    logic x;
    x = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(n)) x = x ^ d[i];
    end
    case (m)
      PAR_EVEN: return x;
      PAR_ODD:  return ~x;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sub        <= '0;
      bitn       <= '0;
      nbits      <= 4'd8;
      shreg      <= '0;
      pbit       <= 1'b0;
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (load) begin
        shreg      <= load_data;
        nbits      <= 4'd5 + {2'b00, cfg.len};
        pbit       <= calc_par(load_data, 4'd5 + {2'b00, cfg.len}, cfg.par);
        par_en_q   <= cfg.par_en;
        two_stop_q <= cfg.two_stop;
        sub        <= '0;
        bitn       <= '0;
        st         <= S_START;
      end
    end else if (tick) begin
      if (sub != SW'(OVS - 1)) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (st)
          S_START: begin
            st   <= S_DATA;
            bitn <= '0;
          end
          S_DATA: begin
            shreg <= shreg >> 1;
            if (bitn == nbits - 4'd1) begin
              bitn <= '0;
              st   <= par_en_q ? S_PAR : S_STOP;
            end else begin
              bitn <= bitn + 4'd1;
            end
          end
          S_PAR: begin
            bitn <= '0;
            st   <= S_STOP;
          end
          S_STOP: begin
            if (two_stop_q && bitn == '0) bitn <= 4'd1;
            else                          st   <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic line;
  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = pbit;
      default: line = 1'b1;
    endcase
  end

  assign txd  = brk ? 1'b0 : line;
  assign idle = (st == S_IDLE);
endmodule

// File: rtl/ser_tx_queue.sv
module ser_tx_queue
  import ser_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int OVS   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         fifo_en,
  input  logic [1:0]   data_len,
  input  logic         parity_en,
  input  logic [1:0]   parity_mode,
  input  logic         two_stop,
  input  logic         break_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         hold_empty,
  output logic         tx_empty,
  output logic         txd
);
  logic [CW-1:0] count;
  logic [W-1:0]  head;
  logic          wr, pop, sh_idle;
  frame_cfg_t    cfg;

  assign in_ready = fifo_en ? (count < CW'(DEPTH)) : (count == '0);
  assign wr       = in_valid && in_ready;
  assign pop      = sh_idle && (count != '0);

  assign cfg.len      = data_len;
  assign cfg.par_en   = parity_en;
  assign cfg.par      = par_mode_e'(parity_mode);
  assign cfg.two_stop = two_stop;

  ser_tx_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .wr_data(in_data),
    .rd_en(pop), .rd_data(head), .count(count)
  );

  ser_tx_shifter #(.W(W), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .load(pop), .load_data(head),
    .cfg(cfg), .brk(break_en), .idle(sh_idle), .txd(txd)
  );

  assign hold_empty = (count == '0);
  assign tx_empty   = hold_empty && sh_idle;
endmodule

// File: rtl/ser_tx_queue_chk.sv
module ser_tx_queue_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_en,
  input logic break_en,
  input logic in_valid,
  input logic in_ready,
  input logic hold_empty,
  input logic tx_empty,
  input logic txd
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !break_en) |-> txd);

  a_r2_single_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !hold_empty) |-> !in_ready);

  a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && tx_empty) |=> (!hold_empty && !tx_empty));

  a_r8_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    break_en |-> !txd);
endmodule

bind ser_tx_queue ser_tx_queue_chk u_chk (.*);

// File: tb/ser_tx_queue_tb.sv
module ser_tx_queue_tb;
  logic clk = 0, rst_n = 0, tick16 = 0;
  logic fifo_en = 0, parity_en = 0, two_stop = 0, break_en = 0, in_valid = 0;
  logic [1:0] data_len = 2'd3, parity_mode = 2'd0;
  logic [7:0] in_data = '0;
  logic in_ready, hold_empty, tx_empty, txd;

  int checks = 0, errors = 0, frames = 0;
  bit mon_en = 1, done = 0;
  logic [7:0] expq [$];
  int tcnt = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= (tcnt == 3) ? 0 : tcnt + 1;
    tick16 <= (tcnt == 3);
  end

  ser_tx_queue u_dut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b; expq.push_back(b);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // monitor: decodes frames at bit centres and compares with the scoreboard
  initial begin
    logic prev;
    prev = 1;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && prev && !txd) begin
        logic [7:0] rx, e;
        logic pb, x;
        int n;
        n = 5 + int'(data_len);
        rx = '0;
        repeat (32) @(negedge clk);
        chk(txd == 0, "R4 start bit", txd, 0);
        for (int i = 0; i < n; i++) begin
          repeat (64) @(negedge clk);
          rx[i] = txd;
        end
        if (expq.size() == 0) begin
          chk(0, "R2 R3 unexpected frame", rx, 0);
          e = '0;
        end else begin
          e = expq.pop_front();
        end
        chk(rx == (e & 8'((1 << n) - 1)), "R3 R4 data", rx, e & 8'((1 << n) - 1));
        if (parity_en) begin
          repeat (64) @(negedge clk);
          pb = txd;
          x = 0;
          for (int i = 0; i < n; i++) x = x ^ e[i];
          case (parity_mode)
            2'd0: x = x;
            2'd1: x = ~x;
            2'd2: x = 1;
            default: x = 0;
          endcase
          chk(pb == x, "R5 parity", pb, x);
        end
        repeat (64) @(negedge clk);
        chk(txd == 1, "R6 stop bit 1", txd, 1);
        if (two_stop) begin
          repeat (64) @(negedge clk);
          chk(txd == 1, "R6 stop bit 2", txd, 1);
        end
        frames++;
        prev = txd;
      end else begin
        prev = txd;
      end
    end
  end

  task automatic run_cfg(logic [1:0] len, logic pe, logic [1:0] pm, logic ts);
    data_len = len; parity_en = pe; parity_mode = pm; two_stop = ts;
    push(8'h5A); push(8'hC3); push(8'h17);
    wait_idle();
    chk(expq.size() == 0, "R4 R5 R6 format run drained", expq.size(), 0);
  endtask

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(hold_empty == 1, "R1 hold_empty", hold_empty, 1);
    chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);

    // single-byte storage
    in_valid = 1; in_data = 8'hA5; expq.push_back(8'hA5);
    @(negedge clk);
    in_valid = 0;
    chk(hold_empty == 0, "R7 byte stored", hold_empty, 0);
    chk(in_ready == 0, "R2 single store full", in_ready, 0);
    chk(tx_empty == 0, "R8 busy", tx_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1, "R7 moved to shifter", hold_empty, 1);
    chk(tx_empty == 0, "R8 shifter busy", tx_empty, 0);
    chk(in_ready == 1, "R2 room again", in_ready, 1);
    chk(txd == 0, "R4 start driven", txd, 0);
    push(8'h3C);
    chk(in_ready == 0, "R2 held while shifting", in_ready, 0);
    in_valid = 1; in_data = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 0;
    while (!hold_empty) @(negedge clk);
    chk(tx_empty == 0, "R8 last frame on line", tx_empty, 0);
    wait_idle();
    chk(frames == 2, "R2 R3 ignored write not sent", frames, 2);

    // queue storage
    fifo_en = 1;
    for (int i = 0; i < 17; i++) push(8'(i * 37 + 1));
    chk(in_ready == 0, "R2 queue full at depth", in_ready, 0);
    chk(hold_empty == 0, "R7 queue occupied", hold_empty, 0);
    for (int i = 0; i < 3; i++) push(8'(i + 8'hF0));
    wait_idle();
    chk(expq.size() == 0, "R3 queue drained in order", expq.size(), 0);
    chk(frames == 22, "R3 frame count", frames, 22);

    // frame formats
    run_cfg(2'd0, 1, 2'd1, 0);
    run_cfg(2'd2, 1, 2'd0, 1);
    run_cfg(2'd1, 1, 2'd2, 0);
    run_cfg(2'd3, 1, 2'd3, 1);
    run_cfg(2'd0, 0, 2'd0, 1);

    // break
    mon_en = 0;
    f0 = frames;
    @(negedge clk);
    break_en = 1;
    @(negedge clk);
    chk(txd == 0, "R9 break low", txd, 0);
    chk(tx_empty == 1 && hold_empty == 1, "R9 status unchanged", {tx_empty, hold_empty}, 3);
    break_en = 0;
    @(negedge clk);
    chk(txd == 1, "R9 released", txd, 1);
    mon_en = 1;
    chk(frames == f0, "R9 no frame", frames, f0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired R3 actual=%0d expected=%0d", frames, 37);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule